// File: doc/BRIEF.md
# Multiphase Sampling Quantizer Front-End

This block is the digital core of a sigma-delta modulator that has several feedback paths and a single integrator. Eight single-bit sampling flip-flops watch one comparator-like input level. Each flip-flop runs on its own phase of a shared-frequency clock, and the rising edges of the phases are evenly spaced across one base period, in order from phase 1 to phase 8. As a result the input is quantized eight times per base period. The effective sampling rate is eight times the clock rate, but no clock runs faster than the base clock.

Each sampler's output leaves the block directly as the feedback bit for its path. All eight feedback bits carry equal weight into an external passive RC integrator, so each contributes one eighth of full scale. The eight samples from one base period are moved into the phase-1 domain through two register ranks and presented as an 8-bit word. One cycle later a count of the ones in that word is presented. That count is the sum of the eight paths, which forms a comb response with nulls at every multiple of the base clock. A valid flag tells downstream decimation logic when the reclock pipeline holds data sampled after reset.

Top module: `mpq_frontend`

## Requirements
- R1: Feedback bit `fb_out[i]` takes the level of `comp_in` at each rising edge of `clk_ph[i]` and holds it until the next rising edge of `clk_ph[i]`. Phase 1 is `clk_ph[0]`.
- R2: Base period n begins at the n-th rising edge of `clk_ph[0]` and lasts until the next one. After the second following rising edge of `clk_ph[0]`, bit i of `word_out` holds the sample taken on `clk_ph[i]` during period n. Bit 0 is the phase-1 sample.
- R3: `ones_cnt` equals the number of ones in `word_out`, with one `clk_ph[0]` cycle of latency after the word. Every path counts with the same weight of one, so the range is 0 to 8.
- R4: While `rst_n` is low, each rising edge of every phase clock clears that domain's registers. `fb_out`, `word_out`, `ones_cnt` and `word_valid` therefore read zero, even when `comp_in` is held high.
- R5: `word_valid` stays low until the second rising edge of `clk_ph[0]` at which `rst_n` is high. It goes high at that edge and then stays high until the next reset.
- R6: A period with every sample high yields `word_out` = 8'hFF and `ones_cnt` = 8. A period with every sample low yields 8'h00 and 0.
- R7: Consecutive periods are independent. When the input pattern changes in every period, each word and each count reflects only its own period's samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ph | input | 8 | Phase clocks of equal frequency. Bit i is phase i+1, and bit 0 also clocks the reclock domain |
| rst_n | input | 1 | Active-low synchronous reset, applied in every phase domain |
| comp_in | input | 1 | Comparator-like input level from the integrator node |
| fb_out | output | 8 | Per-path sampler outputs, used as feedback to the integrator |
| word_out | output | 8 | Reclocked sample word for one base period, bit i from phase i+1 |
| ones_cnt | output | 4 | Number of ones in the previous `word_out` (0 to 8) |
| word_valid | output | 1 | High once the reclock pipeline holds post-reset samples |

## Verification
The hardest thing to set up from the ports is a distinct input level at each of the eight phase edges inside one period. Those edges are only a fraction of a nanosecond apart. The bench therefore steps `comp_in` from a per-period pattern table, with each bit placed midway between two phase edges and the next period's phase-1 bit set just before the next base edge. Walking-one, walking-zero, all-ones, all-zeros, alternating and mixed patterns then reveal both the bit order and the alignment to the correct period. Reset is held while the input is high, so the bench can confirm that the clearing beats the input in every domain.

// File: rtl/mpq_pkg.sv
package mpq_pkg;

  // Number of register ranks between the samplers and the word output.
  localparam int unsigned RECLOCK_STAGES = 2;

  // Widest word the ones-count helper accepts.
  localparam int unsigned ONES_MAXW = 64;

  // Number of set bits in a word; shared by the counter and its checks.
  function automatic int unsigned ones_of(input logic [ONES_MAXW-1:0] v);
    int unsigned n;
    n = 0;
    for (int unsigned b = 0; b < ONES_MAXW; b++) begin
      n += int'(v[b]);
    end
    return n;
  endfunction

endpackage

// File: rtl/mpq_sampler.sv
module mpq_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  // Single-bit quantizer: captures the input level on its own phase edge.
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end

endmodule

// File: rtl/mpq_reclock.sv
module mpq_reclock #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/mpq_ones_count.sv
module mpq_ones_count
  import mpq_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     word,
  output logic [CNT_W-1:0] cnt
);

  logic [ONES_MAXW-1:0] word_wide;
  assign word_wide = ONES_MAXW'(word);

  // Equal-weight sum of all paths, registered once per base cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= CNT_W'(ones_of(word_wide));
  end

endmodule

// File: rtl/mpq_fill_tracker.sv
module mpq_fill_tracker #(
  parameter int unsigned STAGES = 2,
  localparam int unsigned FW    = $clog2(STAGES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  output logic filled
);

  logic [FW-1:0] fill_q;

  // Counts base edges after reset, saturating at the pipeline depth.
  always_ff @(posedge clk) begin
    if (!rst_n)                      fill_q <= '0;
    else if (fill_q != FW'(STAGES))  fill_q <= fill_q + 1'b1;
  end

  assign filled = (fill_q == FW'(STAGES));

  AST_FILL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FW'(STAGES)); // R5

endmodule

// File: rtl/mpq_frontend.sv
module mpq_frontend
  import mpq_pkg::*;
#(
  parameter int unsigned NPATH = 8,
  localparam int unsigned CNT_W = $clog2(NPATH + 1)
) (
  input  logic [NPATH-1:0] clk_ph,
  input  logic             rst_n,
  input  logic             comp_in,
  output logic [NPATH-1:0] fb_out,
  output logic [NPATH-1:0] word_out,
  output logic [CNT_W-1:0] ones_cnt,
  output logic             word_valid
);

  logic base_clk;
  assign base_clk = clk_ph[0];

  // One quantizer per phase; its output doubles as the path feedback.
  generate
    for (genvar g = 0; g < NPATH; g++) begin : g_path
      mpq_sampler u_smp (
        .clk   (clk_ph[g]),
        .rst_n (rst_n),
        .d     (comp_in),
        .q     (fb_out[g])
      );
    end
  endgenerate

  mpq_reclock #(.W(NPATH), .STAGES(RECLOCK_STAGES)) u_rck (
    .clk   (base_clk),
    .rst_n (rst_n),
    .din   (fb_out),
    .dout  (word_out)
  );

  mpq_ones_count #(.W(NPATH), .CNT_W(CNT_W)) u_cnt (
    .clk   (base_clk),
    .rst_n (rst_n),
    .word  (word_out),
    .cnt   (ones_cnt)
  );

  mpq_fill_tracker #(.STAGES(RECLOCK_STAGES)) u_fill (
    .clk    (base_clk),
    .rst_n  (rst_n),
    .filled (word_valid)
  );

  // Observation wire: the count the word seen on the last edge implies.
  logic [ONES_MAXW-1:0] word_wide;
  assign word_wide = ONES_MAXW'(word_out);

  AST_CNT_BOUND: assert property (@(posedge base_clk) disable iff (!rst_n)
    ones_cnt <= CNT_W'(NPATH)); // R3

  AST_CNT_TRACKS_WORD: assert property (@(posedge base_clk) disable iff (!rst_n)
    ones_cnt == CNT_W'(ones_of($past(word_wide)))); // R3

  AST_VALID_STICKY: assert property (@(posedge base_clk) disable iff (!rst_n)
    word_valid |=> word_valid); // R5

  AST_ZERO_UNTIL_VALID: assert property (@(posedge base_clk) disable iff (!rst_n)
    !word_valid |-> (word_out == '0)); // R4

endmodule

// File: tb/mpq_frontend_tb.sv
`timescale 1ns/1ps
module mpq_frontend_tb;

  logic [7:0] clk_ph;
  logic       rst_n;
  logic       comp_in;
  logic [7:0] fb_out;
  logic [7:0] word_out;
  logic [3:0] ones_cnt;
  logic       word_valid;

  mpq_frontend u_dut (
    .clk_ph     (clk_ph),
    .rst_n      (rst_n),
    .comp_in    (comp_in),
    .fb_out     (fb_out),
    .word_out   (word_out),
    .ones_cnt   (ones_cnt),
    .word_valid (word_valid)
  );

  // 200 MHz base clock, eight phases spaced 0.625 ns apart.
  for (genvar g = 0; g < 8; g++) begin : g_clk
    initial begin
      clk_ph[g] = 1'b0;
      #(g * 0.625);
      forever #2.5 clk_ph[g] = ~clk_ph[g];
    end
  end

  logic [7:0] pat_mem    [0:511];
  logic [7:0] word_hist  [0:511];
  logic [7:0] fb_hist    [0:511];
  logic [3:0] cnt_hist   [0:511];
  logic       valid_hist [0:511];
  int edge_n = -1;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  initial begin
    for (int i = 0; i < 512; i++) pat_mem[i] = (i < 4) ? 8'hFF : 8'h00;
  end

  // Driver: bit i of period e is placed 0.3 ns before the phase i+1 edge.
  initial begin
    int e;
    comp_in = 1'b1;
    forever begin
      @(posedge clk_ph[0]);
      edge_n++;
      e = (edge_n < 510) ? edge_n : 510;
      #0.325 comp_in = pat_mem[e][1];
      for (int i = 2; i < 8; i++) begin
        #0.625 comp_in = pat_mem[e][i];
      end
      #0.625 comp_in = pat_mem[e+1][0];
    end
  end

  // Monitor: word/count/valid mid-period, feedback after all phase edges.
  initial begin
    int e;
    forever begin
      @(posedge clk_ph[0]);
      #2.5;
      e = (edge_n < 511) ? edge_n : 511;
      word_hist[e]  = word_out;
      cnt_hist[e]   = ones_cnt;
      valid_hist[e] = word_valid;
      #2.3;
      fb_hist[e] = fb_out;
    end
  end

  initial begin
    rst_n = 1'b0;
    wait (edge_n == 4);
    #1.2 rst_n = 1'b1;
  end

  function automatic int ref_ones(input logic [7:0] v);
    int n = 0;
    logic [7:0] t = v;
    while (t != 0) begin
      t = t & (t - 8'd1);
      n++;
    end
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Plays a pattern list in future periods and checks all three outputs.
  task automatic play(input logic [7:0] p [16], input int len, input string tag);
    int base = edge_n + 2;
    for (int k = 0; k < len; k++) pat_mem[base+k] = p[k];
    wait (edge_n >= base + len + 4);
    #3;
    for (int k = 0; k < len; k++) begin
      logic [7:0] v = pat_mem[base+k];
      chk(fb_hist[base+k] == v, "R1", {tag, " fb_out"}, fb_hist[base+k], v);
      chk(word_hist[base+k+2] == v, "R2", {tag, " word_out"}, word_hist[base+k+2], v);
      chk(int'(cnt_hist[base+k+3]) == ref_ones(v), "R3", {tag, " ones_cnt"},
          cnt_hist[base+k+3], ref_ones(v));
    end
  endtask

  task automatic t_reset;
    // R4: input held high through reset; everything must read zero.
    chk(fb_hist[3] == 8'h00, "R4", "fb_out in reset", fb_hist[3], 0);
    chk(word_hist[3] == 8'h00, "R4", "word_out in reset", word_hist[3], 0);
    chk(cnt_hist[3] == 4'd0, "R4", "ones_cnt in reset", cnt_hist[3], 0);
    chk(valid_hist[3] == 1'b0, "R4", "word_valid in reset", valid_hist[3], 0);
    // R5: first edge with rst_n high is 5, second is 6.
    chk(valid_hist[5] == 1'b0, "R5", "valid after first edge", valid_hist[5], 0);
    chk(valid_hist[6] == 1'b1, "R5", "valid after second edge", valid_hist[6], 1);
  endtask

  task automatic t_walk;
    logic [7:0] p [16];
    for (int k = 0; k < 8; k++) begin
      p[k]   = 8'h01 << k;
      p[k+8] = ~(8'h01 << k);
    end
    play(p, 16, "R2 walk");
  endtask

  task automatic t_extremes;
    logic [7:0] p [16];
    for (int k = 0; k < 16; k++) p[k] = 8'h00;
    p[0] = 8'hFF; p[1] = 8'h00; p[2] = 8'hFF; p[3] = 8'hFF; p[4] = 8'h00;
    play(p, 5, "R6 extremes");
  endtask

  task automatic t_alternate;
    logic [7:0] p [16];
    for (int k = 0; k < 16; k++) p[k] = (k % 2 == 0) ? 8'hAA : 8'h55;
    play(p, 10, "R7 alternate");
  endtask

  task automatic t_mixed;
    logic [7:0] p [16];
    logic [7:0] s = 8'h5B;
    for (int k = 0; k < 16; k++) begin
      p[k] = s;
      s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    end
    play(p, 16, "R7 mixed");
  endtask

  task automatic t_valid_sticky;
    int drops = 0;
    for (int k = 6; k < edge_n; k++) if (valid_hist[k] !== 1'b1) drops++;
    chk(drops == 0, "R5", "valid dropped count", drops, 0);
  endtask

  initial begin
    wait (edge_n == 8);
    #3;
    t_reset;
    t_walk;
    t_extremes;
    t_alternate;
    t_mixed;
    t_valid_sticky;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule